// File: doc/BRIEF.md
# Oscillator Frequency Check and Tracking-Mode Selector

This block decides whether a clock-recovery loop should follow the incoming serial data or fall back to a local reference clock. It receives two single-cycle enable streams in one clock domain. The first is a tick for every eighth cycle of the local oscillator. The second is a tick for every reference-clock cycle, whose nominal rate is one eighth of the bit rate.

Over a window of a fixed number of reference ticks, the block counts the oscillator ticks. It compares the count against the nominal value and passes the result through a two-threshold hysteresis stage. The stage gives a "frequency near" flag.

That flag is combined with two inputs: a signal-detect input from the optical front end and a data-valid indication from a data-integrity checker. Data tracking is chosen only when all three are good. The choice appears on an active-high output that means "tracking the reference, not locked to data".

Top module: `freq_lock_ctrl`

## Requirements
- R1: After reset, `ref_mode` is 1 and the frequency state is "far". It stays far, and `ref_mode` stays 1, until a window ends with an error below the near limit, whatever the levels of `sig_det` and `data_ok`.
- R2: A measurement window closes on the WINDOW_TICKS-th `ref_tick` (default 2000). Its oscillator count includes every `osc_tick` from the cycle after the previous close up to and including the closing cycle.
- R3: A window whose absolute count error is greater than GROSS_LIMIT (default 30) sets the frequency state to far.
- R4: A window whose absolute count error is less than NEAR_LIMIT (default 10) sets the frequency state to near.
- R5: A window whose error is from NEAR_LIMIT to GROSS_LIMIT inclusive leaves the frequency state unchanged. This holds at both boundary values 10 and 30.
- R6: `sig_det` low makes `ref_mode` 1 at the next clock edge, with no filtering.
- R7: `data_ok` low makes `ref_mode` 1 at the next clock edge.
- R8: `ref_mode` is 0 (data tracking) only when the frequency state is near, `sig_det` is 1 and `data_ok` is 1. Otherwise it is 1.
- R9: The frequency state changes at the clock edge after the one that samples the closing `ref_tick`. `ref_mode` follows one edge after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; both tick streams are enables in this domain |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| osc_tick | input | 1 | One-cycle pulse per eight local-oscillator periods |
| sig_det | input | 1 | Optical signal present (1) or lost (0) |
| data_ok | input | 1 | Data-integrity checker reports no failure (1) |
| ref_mode | output | 1 | 1 = tracking reference clock, 0 = tracking data |

## Verification
Results of a measurement window come through three registers. The count is captured at the edge that samples the closing reference tick. The frequency state follows one edge later, and `ref_mode` one edge after that. Signal-detect and data-valid changes reach `ref_mode` after a single edge.

The bench drives every input on the falling clock edge. It runs windows of 4000 cycles, with a reference tick every other cycle, and places oscillator ticks well clear of the window boundaries. The table checks sample 50 cycles into the following window, once all three registers have settled. The directed checks sample on the exact cycles before and after the expected edge, which pins both latencies.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic {
        FREQ_FAR  = 1'b0,
        FREQ_NEAR = 1'b1
    } freq_e;

    typedef enum logic {
        TRACK_DATA = 1'b0,
        TRACK_REF  = 1'b1
    } track_e;

    function automatic int unsigned abs_gap(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/tick_window.sv
module tick_window #(
    parameter int WINDOW = 2000,
    parameter int CNT_W  = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             osc_tick,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_count
);
    localparam int REF_W = $clog2(WINDOW);

    logic [REF_W-1:0] ref_cnt;
    logic [CNT_W-1:0] osc_cnt;
    logic [CNT_W-1:0] osc_next;
    logic             closing;

    always_comb begin
        osc_next = osc_cnt;
        if (osc_tick && (osc_cnt != {CNT_W{1'b1}}))
            osc_next = osc_cnt + 1'b1;
        closing = ref_tick && (ref_cnt == REF_W'(WINDOW - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_cnt    <= '0;
            osc_cnt    <= '0;
            meas_valid <= 1'b0;
            meas_count <= '0;
        end else begin
            meas_valid <= closing;
            if (closing) begin
                meas_count <= osc_next;
                ref_cnt    <= '0;
                osc_cnt    <= '0;
            end else begin
                if (ref_tick)
                    ref_cnt <= ref_cnt + 1'b1;
                osc_cnt <= osc_next;
            end
        end
    end

    // A result only appears on the cycle after a reference tick closed the window
    p_close_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        meas_valid |-> $past(ref_tick));

    p_ref_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        ref_cnt <= REF_W'(WINDOW - 1));

endmodule

// File: rtl/freq_judge.sv
module freq_judge
    import lock_pkg::*;
#(
    parameter int WINDOW = 2000,
    parameter int CNT_W  = 13,
    parameter int GROSS  = 30,
    parameter int NEAR   = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_count,
    output freq_e            freq_state
);
    int unsigned gap;

    always_comb gap = abs_gap(32'(meas_count), 32'(WINDOW));

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_state <= FREQ_FAR;
        end else if (meas_valid) begin
            if (gap > 32'(GROSS))
                freq_state <= FREQ_FAR;
            else if (gap < 32'(NEAR))
                freq_state <= FREQ_NEAR;
        end
    end

    p_gross_far_r3: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && gap > 32'(GROSS)) |=> (freq_state == FREQ_FAR));

    p_close_near_r4: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && gap < 32'(NEAR)) |=> (freq_state == FREQ_NEAR));

    p_hold_band_r5: assert property (@(posedge clk) disable iff (rst)
        (!meas_valid || (gap >= 32'(NEAR) && gap <= 32'(GROSS))) |=> $stable(freq_state));

endmodule

// File: rtl/mode_select.sv
module mode_select
    import lock_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  freq_e freq_state,
    input  logic  sig_det,
    input  logic  data_ok,
    output logic  ref_mode
);
    track_e track_q;

    always_ff @(posedge clk) begin
        if (rst)
            track_q <= TRACK_REF;
        else if (freq_state == FREQ_NEAR && sig_det && data_ok)
            track_q <= TRACK_DATA;
        else
            track_q <= TRACK_REF;
    end

    assign ref_mode = (track_q == TRACK_REF);

    p_sigdet_forces_r6: assert property (@(posedge clk) disable iff (rst)
        !sig_det |=> ref_mode);

    p_dataok_forces_r7: assert property (@(posedge clk) disable iff (rst)
        !data_ok |=> ref_mode);

    p_far_forces_r8: assert property (@(posedge clk) disable iff (rst)
        (freq_state == FREQ_FAR) |=> ref_mode);

    p_data_needs_all_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_mode) |-> $past(freq_state == FREQ_NEAR && sig_det && data_ok));

endmodule

// File: rtl/freq_lock_ctrl.sv
module freq_lock_ctrl
    import lock_pkg::*;
#(
    parameter int WINDOW_TICKS = 2000,
    parameter int GROSS_LIMIT  = 30,
    parameter int NEAR_LIMIT   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic osc_tick,
    input  logic sig_det,
    input  logic data_ok,
    output logic ref_mode
);
    localparam int CNT_W = $clog2(4 * WINDOW_TICKS);

    logic             meas_valid;
    logic [CNT_W-1:0] meas_count;
    freq_e            freq_state;

    tick_window #(
        .WINDOW (WINDOW_TICKS),
        .CNT_W  (CNT_W)
    ) u_window (
        .clk        (clk),
        .rst        (rst),
        .ref_tick   (ref_tick),
        .osc_tick   (osc_tick),
        .meas_valid (meas_valid),
        .meas_count (meas_count)
    );

    freq_judge #(
        .WINDOW (WINDOW_TICKS),
        .CNT_W  (CNT_W),
        .GROSS  (GROSS_LIMIT),
        .NEAR   (NEAR_LIMIT)
    ) u_judge (
        .clk        (clk),
        .rst        (rst),
        .meas_valid (meas_valid),
        .meas_count (meas_count),
        .freq_state (freq_state)
    );

    mode_select u_mode (
        .clk        (clk),
        .rst        (rst),
        .freq_state (freq_state),
        .sig_det    (sig_det),
        .data_ok    (data_ok),
        .ref_mode   (ref_mode)
    );

    // Frequency state may only move on the cycle after a window result
    p_state_after_result_r9: assert property (@(posedge clk) disable iff (rst)
        (freq_state != $past(freq_state)) |-> $past(meas_valid));

endmodule

// File: tb/sim_freq_lock_ctrl.sv
module sim_freq_lock_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_tick = 1'b0;
    logic osc_tick = 1'b0;
    logic sig_det = 1'b0;
    logic data_ok = 1'b0;
    logic ref_mode;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    freq_lock_ctrl u0 (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .osc_tick (osc_tick),
        .sig_det  (sig_det),
        .data_ok  (data_ok),
        .ref_mode (ref_mode)
    );

    // Window = 2000 reference ticks, one every other cycle -> 4000 cycles.
    // Oscillator count per window, sig_det, data_ok, expected ref_mode after.
    localparam int NV = 13;
    localparam int VEC_N  [NV] = '{2000, 2020, 2031, 2020, 2010, 2009, 2030,
                                   1969, 1991, 1995, 2000, 2000, 0};
    localparam bit VEC_SD [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 1, 1};
    localparam bit VEC_OK [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 1};
    localparam bit VEC_EX [NV] = '{0, 0, 1, 1, 1, 0, 0, 1, 0, 1, 1, 0, 1};

    function automatic string req_of(input int i);
        case (i)
            0:          return "R2 R4";
            1, 3, 4, 6: return "R5";
            2, 7, 12:   return "R3";
            5, 8:       return "R4";
            9:          return "R6";
            10:         return "R7";
            default:    return "R8";
        endcase
    endfunction

    task automatic check(input logic got, input logic exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: ref_mode=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // One 4000-cycle window. Checks at offsets ca/cb (negative = none) are
    // taken before that cycle's inputs are driven.
    task automatic run_window(input int n, input bit sd, input bit ok,
                              input int ca, input bit ea, input string ra,
                              input int cb, input bit eb, input string rb);
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (c == ca) check(ref_mode, ea, ra);
            if (c == cb) check(ref_mode, eb, rb);
            ref_tick = (c % 2 == 0);
            osc_tick = (c >= 200) && (c < 200 + n);
            if (c == 100) begin
                sig_det = sd;
                data_ok = ok;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ref_mode, 1'b1, "R1");
        rst = 1'b0;

        run_window(VEC_N[0], VEC_SD[0], VEC_OK[0], -1, 1'b0, "", -1, 1'b0, "");
        for (int i = 1; i < NV; i++)
            run_window(VEC_N[i], VEC_SD[i], VEC_OK[i],
                       50, VEC_EX[i-1], req_of(i-1), -1, 1'b0, "");
        // Last table entry checked; this window brings the state back to near
        run_window(2000, 1'b1, 1'b1, 50, VEC_EX[NV-1], req_of(NV-1), -1, 1'b0, "");
        // R9: mode still reference one cycle after the state update, data the next
        run_window(2000, 1'b1, 1'b1, 0, 1'b1, "R9", 1, 1'b0, "R9");
        // R6: signal loss takes effect after exactly one edge
        run_window(2000, 1'b0, 1'b1, 100, 1'b0, "R6", 101, 1'b1, "R6");

        // R1: reset in the middle of operation returns to far / reference
        @(negedge clk);
        rst = 1'b1;
        ref_tick = 1'b0;
        osc_tick = 1'b0;
        sig_det = 1'b1;
        data_ok = 1'b1;
        repeat (2) @(negedge clk);
        check(ref_mode, 1'b1, "R1");
        rst = 1'b0;
        // Error of exactly 10 keeps the reset far state despite good inputs
        run_window(2010, 1'b1, 1'b1, 150, 1'b1, "R1", -1, 1'b0, "");
        run_window(2000, 1'b1, 1'b1, 50, 1'b1, "R1", -1, 1'b0, "");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule